// File: doc/BRIEF.md
# Rectangle Draw-Cost Estimator

This block estimates how many drawing cycles a rectangle fill or sprite will take. It takes a rectangle and a drawing (clip) area. Both are given as a left and top edge that are included and a right and bottom edge that are excluded. The block intersects the two to find the width and height that are actually drawn.

It then builds a cost for one row from several parts:

- a base cost equal to the drawn width;
- an extra texture-fetch term that depends on the texture format;
- for formats that go through the texture cache, a term that depends on whether the rows fit the cache;
- a blending term for semitransparent or mask-checked pixels.

Finally it multiplies the row cost by the number of rows drawn. Fewer rows are counted when only one field of an interlaced frame is drawn.

The surrounding pipeline pulses `start` with the operands valid in the same cycle. Exactly three clock edges later, `done` pulses for one cycle and `total` carries the cost. The caller adds that cost to its pending-cycle counter. `total` keeps its last value until the next result. A new `start` may be issued every cycle.

Top module: `rect_cost_est`

## Requirements
- R1: The drawn width is max(0, min(rect_r, clip_r) - max(rect_l, clip_l)), and the drawn height is computed the same way from the top and bottom edges. If either one is zero, `total` is 0.
- R2: The per-row cost starts at the drawn width w. When `textured` is 0, `tex_mode` has no effect.
- R3: When textured with `tex_mode` = 0 (4-bit palette), w is added again to the per-row cost.
- R4: When textured with `tex_mode` = 1 (8-bit palette), the per-row cost gains one of three amounts, with h the drawn height before field skipping:
  - (w/4)*8 if w > 128;
  - otherwise (w/4)*4*(128/w) if w*h > 2048;
  - otherwise w.

  All divisions truncate.
- R5: When textured with `tex_mode` = 2 or 3 (16-bit direct), the per-row cost gains one of three amounts:
  - (w/2)*8 if w > 128;
  - otherwise (w/4)*8*(128/w) if w*h > 1024;
  - otherwise w.
- R6: If `semi_trans` or `mask_check` is 1, (w+1)/2 is added to the per-row cost.
- R7: With `field_skip` = 1, the rows counted are max(h/2, 1) for a non-empty rectangle.
- R8: `total` is the per-row cost times the rows counted. It appears with a one-cycle `done` pulse exactly three rising edges after the edge that samples `start`. Between results, `total` holds its value.
- R9: After reset, `done` is 0 and `total` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operands valid, begin an estimate |
| rect_l | input | CW | Rectangle left edge (included) |
| rect_t | input | CW | Rectangle top edge (included) |
| rect_r | input | CW | Rectangle right edge (excluded) |
| rect_b | input | CW | Rectangle bottom edge (excluded) |
| clip_l | input | CW | Drawing-area left edge (included) |
| clip_t | input | CW | Drawing-area top edge (included) |
| clip_r | input | CW | Drawing-area right edge (excluded) |
| clip_b | input | CW | Drawing-area bottom edge (excluded) |
| textured | input | 1 | Rectangle samples a texture |
| tex_mode | input | 2 | 0: 4-bit palette, 1: 8-bit palette, 2/3: 16-bit direct |
| semi_trans | input | 1 | Semitransparent blending |
| mask_check | input | 1 | Mask bit checked before each write |
| field_skip | input | 1 | Only one interlace field is drawn |
| done | output | 1 | Result strobe |
| total | output | 2*CW+3 | Estimated cycle cost |

## Verification
The bench aims at the places where the cache formula changes branch:

- A width of exactly 128 against 129. A design with the wrong comparison would charge the wide-row rate one step early or late.
- Areas just at and just above the 2048 and 1024 thresholds. Swapping the thresholds between the two formats, or using the halved height for the area, shows up as a different cost.
- Rectangles that extend past the clip area, and ones that do not overlap it at all. A design that skips the intersection, or that applies the minimum of one row to an empty rectangle, reports a nonzero cost.
- A one-row rectangle with field skipping. Losing the minimum here gives zero.
- `tex_mode` 3 compared with 2, and a non-textured rectangle with every mode code. These catch a decode that reads the mode when it should not.

// File: rtl/rect_cost_est.sv
module rect_cost_est #(
  parameter int CW       = 11,
  parameter int WIDE_W   = 128,
  parameter int AREA_P8  = 2048,
  parameter int AREA_D16 = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CW-1:0]     rect_l,
  input  logic [CW-1:0]     rect_t,
  input  logic [CW-1:0]     rect_r,
  input  logic [CW-1:0]     rect_b,
  input  logic [CW-1:0]     clip_l,
  input  logic [CW-1:0]     clip_t,
  input  logic [CW-1:0]     clip_r,
  input  logic [CW-1:0]     clip_b,
  input  logic              textured,
  input  logic [1:0]        tex_mode,
  input  logic              semi_trans,
  input  logic              mask_check,
  input  logic              field_skip,
  output logic              done,
  output logic [2*CW+2:0]   total
);
  localparam int TW = 2*CW + 3;
  localparam logic [TW-1:0] K_WIDE = TW'(WIDE_W);
  localparam logic [TW-1:0] K_A8   = TW'(AREA_P8);
  localparam logic [TW-1:0] K_A16  = TW'(AREA_D16);
  localparam logic [TW-1:0] K_ONE  = TW'(1);

  // stage 1: clip intersection
  logic [CW-1:0] lo_x, hi_x, lo_y, hi_y;
  assign lo_x = (rect_l > clip_l) ? rect_l : clip_l;
  assign hi_x = (rect_r < clip_r) ? rect_r : clip_r;
  assign lo_y = (rect_t > clip_t) ? rect_t : clip_t;
  assign hi_y = (rect_b < clip_b) ? rect_b : clip_b;

  logic          v1, tex1, blend1, skip1;
  logic [1:0]    mode1;
  logic [CW-1:0] w1, h1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; w1 <= '0; h1 <= '0;
      tex1 <= 1'b0; mode1 <= '0; blend1 <= 1'b0; skip1 <= 1'b0;
    end else begin
      v1     <= start;
      w1     <= (hi_x > lo_x) ? hi_x - lo_x : '0;
      h1     <= (hi_y > lo_y) ? hi_y - lo_y : '0;
      tex1   <= textured;
      mode1  <= tex_mode;
      blend1 <= semi_trans | mask_check;
      skip1  <= field_skip;
    end
  end

  // stage 2: per-row cost and counted rows
  logic [TW-1:0] wx, hx, area, q, extra, row, rows;
  logic          empty1;
  assign wx     = TW'(w1);
  assign hx     = TW'(h1);
  assign area   = wx * hx;
  assign empty1 = (w1 == '0) || (h1 == '0);
  assign q      = (!empty1 && wx <= K_WIDE) ? K_WIDE / wx : '0;

  always_comb begin
    unique case (mode1)
      2'd0: extra = wx;
      2'd1: extra = (wx > K_WIDE) ? (wx >> 2) * TW'(8)
                  : (area > K_A8) ? (wx >> 2) * (q << 2) : wx;
      default: extra = (wx > K_WIDE) ? (wx >> 1) * TW'(8)
                     : (area > K_A16) ? (wx >> 2) * (q << 3) : wx;
    endcase
  end

  assign row  = wx + (tex1 ? extra : '0) + (blend1 ? (wx + K_ONE) >> 1 : '0);
  assign rows = empty1 ? '0 : !skip1 ? hx : (h1 < CW'(2)) ? K_ONE : hx >> 1;

  logic          v2;
  logic [TW-1:0] row2, rows2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; row2 <= '0; rows2 <= '0;
    end else begin
      v2    <= v1;
      row2  <= row;
      rows2 <= rows;
    end
  end

  // stage 3: product
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      total <= '0;
    end else begin
      done <= v2;
      if (v2) total <= row2 * rows2;
    end
  end
endmodule

// File: rtl/rect_cost_est_chk.sv
module rect_cost_est_chk #(
  parameter int CW = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CW-1:0]     rect_l,
  input logic [CW-1:0]     rect_r,
  input logic              done,
  input logic [2*CW+2:0]   total
);
  // R9
  a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && total == '0));

  // R8
  a_r8_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 3));

  // R8
  a_r8_total_holds: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(total));

  // R1
  a_r1_degenerate_zero: assert property (@(posedge clk) disable iff (rst)
    (done && $past(rect_r <= rect_l, 3)) |-> total == '0);
endmodule

bind rect_cost_est rect_cost_est_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .rect_l(rect_l), .rect_r(rect_r),
  .done(done), .total(total));

// File: tb/rect_cost_est_tb_top.sv
`timescale 1ns/100ps
module rect_cost_est_tb_top;
  localparam int CW = 11;
  localparam int TW = 2*CW + 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] rect_l = '0, rect_t = '0, rect_r = '0, rect_b = '0;
  logic [CW-1:0] clip_l = '0, clip_t = '0, clip_r = '0, clip_b = '0;
  logic textured = 1'b0, semi_trans = 1'b0, mask_check = 1'b0, field_skip = 1'b0;
  logic [1:0] tex_mode = '0;
  logic done;
  logic [TW-1:0] total;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rect_cost_est #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .rect_l(rect_l), .rect_t(rect_t), .rect_r(rect_r), .rect_b(rect_b),
    .clip_l(clip_l), .clip_t(clip_t), .clip_r(clip_r), .clip_b(clip_b),
    .textured(textured), .tex_mode(tex_mode), .semi_trans(semi_trans),
    .mask_check(mask_check), .field_skip(field_skip),
    .done(done), .total(total));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic longint expect_cost(int rl, int rt, int rr, int rb,
      int cl, int ct, int cr, int cb, bit tx, int md, bit sm, bit mk, bit sk);
    int lo, hi, w, h, hr, q;
    longint row;
    lo = (rl > cl) ? rl : cl; hi = (rr < cr) ? rr : cr;
    w = (hi > lo) ? hi - lo : 0;
    lo = (rt > ct) ? rt : ct; hi = (rb < cb) ? rb : cb;
    h = (hi > lo) ? hi - lo : 0;
    if (w == 0 || h == 0) return 0;
    q = (w <= 128) ? 128 / w : 0;
    row = w;
    if (tx) begin
      if (md == 0) row += w;
      else if (md == 1) row += (w > 128) ? (w/4)*8 : (w*h > 2048) ? (w/4)*(4*q) : w;
      else row += (w > 128) ? (w/2)*8 : (w*h > 1024) ? (w/4)*(8*q) : w;
    end
    if (sm || mk) row += (w + 1) / 2;
    hr = sk ? ((h/2 > 1) ? h/2 : 1) : h;
    return row * hr;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(string req, int rl, int rt, int rr, int rb,
      int cl, int ct, int cr, int cb, bit tx, int md, bit sm, bit mk, bit sk);
    longint exp;
    exp = expect_cost(rl, rt, rr, rb, cl, ct, cr, cb, tx, md, sm, mk, sk);
    rect_l = CW'(rl); rect_t = CW'(rt); rect_r = CW'(rr); rect_b = CW'(rb);
    clip_l = CW'(cl); clip_t = CW'(ct); clip_r = CW'(cr); clip_b = CW'(cb);
    textured = tx; tex_mode = 2'(md); semi_trans = sm; mask_check = mk; field_skip = sk;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(req, "done before latency", longint'(done), 0);
    @(negedge clk);
    check(req, "done strobe", longint'(done), 1);
    check(req, "total", longint'(total), exp);
    @(negedge clk);
    check(req, "done drops", longint'(done), 0);
    check(req, "total held", longint'(total), exp);
  endtask

  task automatic test_reset();
    check("R9", "done after reset", longint'(done), 0);
    check("R9", "total after reset", longint'(total), 0);
  endtask

  task automatic test_clip();
    run("R1", 100, 50, 300, 90, 0, 0, 1024, 512, 0, 0, 0, 0, 0);
    run("R1", 10, 10, 200, 200, 50, 60, 120, 100, 0, 0, 0, 0, 0);
    run("R1", 10, 10, 40, 40, 50, 50, 90, 90, 1, 0, 1, 0, 1);
    run("R1", 60, 10, 60, 40, 0, 0, 200, 200, 1, 1, 0, 0, 0);
  endtask

  task automatic test_plain();
    for (int m = 0; m < 4; m++)
      run("R2", 0, 0, 200, 30, 0, 0, 1024, 512, 0, m, 0, 0, 0);
  endtask

  task automatic test_p4();
    run("R3", 5, 5, 69, 37, 0, 0, 1024, 512, 1, 0, 0, 0, 0);
  endtask

  task automatic test_p8();
    run("R4", 0, 0, 129, 4, 0, 0, 1024, 512, 1, 1, 0, 0, 0);
    run("R4", 0, 0, 128, 16, 0, 0, 1024, 512, 1, 1, 0, 0, 0);
    run("R4", 0, 0, 128, 17, 0, 0, 1024, 512, 1, 1, 0, 0, 0);
    run("R4", 0, 0, 64, 64, 0, 0, 1024, 512, 1, 1, 0, 0, 0);
    run("R4", 0, 0, 30, 80, 0, 0, 1024, 512, 1, 1, 0, 0, 0);
  endtask

  task automatic test_d16();
    run("R5", 0, 0, 200, 3, 0, 0, 1024, 512, 1, 2, 0, 0, 0);
    run("R5", 0, 0, 32, 32, 0, 0, 1024, 512, 1, 2, 0, 0, 0);
    run("R5", 0, 0, 32, 40, 0, 0, 1024, 512, 1, 2, 0, 0, 0);
    run("R5", 0, 0, 32, 40, 0, 0, 1024, 512, 1, 3, 0, 0, 0);
    run("R5", 0, 0, 40, 40, 0, 0, 1024, 512, 1, 2, 0, 0, 0);
  endtask

  task automatic test_blend();
    run("R6", 0, 0, 33, 10, 0, 0, 1024, 512, 0, 0, 1, 0, 0);
    run("R6", 0, 0, 33, 10, 0, 0, 1024, 512, 1, 1, 0, 1, 0);
  endtask

  task automatic test_skip();
    run("R7", 0, 0, 50, 9, 0, 0, 1024, 512, 0, 0, 0, 0, 1);
    run("R7", 0, 0, 50, 1, 0, 0, 1024, 512, 1, 2, 1, 0, 1);
    run("R7", 0, 0, 64, 64, 0, 0, 1024, 512, 1, 1, 0, 0, 1);
  endtask

  task automatic test_b2b();
    longint e1, e2;
    e1 = expect_cost(0, 0, 10, 10, 0, 0, 1024, 512, 0, 0, 0, 0, 0);
    e2 = expect_cost(0, 0, 20, 5, 0, 0, 1024, 512, 1, 0, 0, 0, 0);
    rect_l = '0; rect_t = '0; rect_r = CW'(10); rect_b = CW'(10);
    clip_l = '0; clip_t = '0; clip_r = CW'(1024); clip_b = CW'(512);
    textured = 0; tex_mode = '0; semi_trans = 0; mask_check = 0; field_skip = 0;
    start = 1'b1;
    @(negedge clk);
    rect_r = CW'(20); rect_b = CW'(5); textured = 1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R8", "b2b first", longint'(total), e1);
    check("R8", "b2b first strobe", longint'(done), 1);
    @(negedge clk);
    check("R8", "b2b second", longint'(total), e2);
    check("R8", "b2b second strobe", longint'(done), 1);
    repeat (3) @(negedge clk);
    check("R8", "idle after b2b", longint'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_clip();
    test_plain();
    test_p4();
    test_p8();
    test_d16();
    test_blend();
    test_skip();
    test_b2b();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule